// File: doc/BRIEF.md
# PCM Serial Transmit Shifter

This block is the outbound serial engine of a PCM audio port. It divides the system clock into a bit clock and marks the start of each 16-bit slot with a frame-sync pulse. At every slot boundary it takes one sample from an upstream sample queue over a valid/ready handshake. It then shifts the sample out on a single data pin, most significant bit first.

Two independent gates control it. The port enable holds the shifter and the slot bit counter in reset. While the port enable is low, the data pin and the frame sync stay low and no samples are taken. The clock enable parks the bit clock and the frame sync low and freezes the slot position and the shift contents. No samples are taken while it is low, and when it returns the slot continues from where it stopped.

Back-pressure rules: `s_ready` is a one-cycle pulse and never waits on `s_valid`. A sample is consumed only in a cycle where `s_valid` and `s_ready` are both high. If `s_valid` is low at the pulse, the slot transmits zeros and no retry is made until the next slot. The upstream queue should present `s_valid` whenever it is not empty and must hold `s_data` stable while `s_valid` is high.

Top module: `pcm_tx_shifter`

## Requirements
- R1: The bit clock `bclk` starts low after reset. It toggles every `div+1` system clocks while `sclk_en` is high, giving a period of 2×(`div`+1) system clocks. Its rising edge is the edge on which `sdo` and `fsync` change.
- R2: A slot spans 16 bit-clock periods. `fsync` goes high on the rising `bclk` edge that starts a slot and falls on the next rising edge, so it is high for one bit-clock period.
- R3: `s_ready` pulses high for exactly one system clock in the cycle before the slot-start rising edge. It never pulses at any other time. A sample is taken only if `s_valid` is high in that cycle.
- R4: A taken sample goes out MSB first. The MSB appears on `sdo` at the rising edge after the slot start. The LSB appears at the rising edge that starts the following slot.
- R5: If `s_valid` is low at the slot start, all 16 bits of that slot are 0. `underrun` is high from that slot start to the next slot start that finds `s_valid` high.
- R6: While `port_en` is low, `sdo`, `fsync` and `underrun` are low from the next system clock on, and `s_ready` never pulses. The bit clock keeps running if `sclk_en` is high.
- R7: When `port_en` rises, the abandoned sample is not resumed. The first rising `bclk` edge starts a new slot, with `fsync` high and a fresh sample taken.
- R8: While `sclk_en` is low, `bclk` and `fsync` are low from the next system clock on, and `s_ready` never pulses.
- R9: When `sclk_en` returns high, the slot continues at the bit position where it stopped, so the interrupted sample is transmitted intact.
- R10: During reset, and in the first cycle after it, `bclk`, `fsync`, `sdo`, `underrun` and `s_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port enable; low holds shifter and bit counter in reset |
| sclk_en | input | 1 | Serial clock enable; low parks bit clock and frame sync |
| div | input | DIV_W | Half-period of the bit clock minus one, in system clocks |
| s_valid | input | 1 | Upstream has a sample available |
| s_ready | output | 1 | One-cycle pulse at slot start; sample consumed when s_valid is high |
| s_data | input | SAMPLE_W | Sample to transmit |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync, one bit-clock period at slot start |
| sdo | output | 1 | Serial data out, MSB first |
| underrun | output | 1 | Current slot is transmitting zeros for lack of a sample |

## Verification
At a slot boundary, two things happen on the same rising bit-clock edge. The previous sample's LSB is launched, and the next sample is loaded. The vector walk checks every captured word from its MSB through its LSB, with the LSB sampled on that shared edge, so a late load or an extra shift corrupts the last bit. The second collision is a gate landing mid-slot. The port enable is dropped partway through a sample, and the bench then checks that the next word arrives whole and in a fresh slot. The clock enable is also dropped partway through a word, and the bench checks that the word completes intact after the clock resumes.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int SAMPLE_W_DEF = 16;
  localparam int DIV_W_DEF    = 8;
endpackage

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_en,
  input  logic [DIV_W-1:0] div,
  output logic             bclk,
  output logic             rise
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit  = (cnt >= div);
  assign rise = sclk_en && hit && !bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (!sclk_en) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (hit) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R8: parked bit clock
  a_r8_bclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_en |=> !bclk);
  // R1: no toggle before the divider expires
  a_r1_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en && !hit) |=> $stable(bclk));
endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl #(
  parameter int SAMPLE_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic sclk_en,
  input  logic rise,
  input  logic s_valid,
  output logic slot_start,
  output logic fsync,
  output logic underrun
);
  localparam int CNT_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

  logic [CNT_W-1:0] bitcnt;

  assign slot_start = port_en && rise && (bitcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      fsync    <= 1'b0;
      underrun <= 1'b0;
    end else if (!port_en) begin
      bitcnt   <= '0;
      fsync    <= 1'b0;
      underrun <= 1'b0;
    end else if (!sclk_en) begin
      fsync    <= 1'b0;
    end else if (rise) begin
      fsync  <= (bitcnt == '0);
      bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + 1'b1;
      if (bitcnt == '0) underrun <= !s_valid;
    end
  end

  // R6: frame sync off while port disabled
  a_r6_fsync_off: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !fsync);
  // R8: frame sync parked with the clock
  a_r8_fsync_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_en |=> !fsync);
  // R3: each frame sync follows a pop opportunity
  a_r3_fsync_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $past(slot_start));
  // R5: underrun only from an empty slot start
  a_r5_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(slot_start && !s_valid));
endmodule

// File: rtl/pcm_shift_reg.sv
module pcm_shift_reg #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_en,
  input  logic                rise,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] load_data,
  output logic                sdo
);
  logic [SAMPLE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      sdo   <= 1'b0;
    end else if (!port_en) begin
      shreg <= '0;
      sdo   <= 1'b0;
    end else if (rise) begin
      sdo   <= shreg[SAMPLE_W-1];
      shreg <= load ? load_data : {shreg[SAMPLE_W-2:0], 1'b0};
    end
  end

  // R6: data pin low while port disabled
  a_r6_sdo_low: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !sdo);
  // R4: data changes only on a bit-clock rise
  a_r4_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !rise) |=> $stable(sdo));
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
  import pcm_tx_pkg::*;
#(
  parameter int DIV_W    = DIV_W_DEF,
  parameter int SAMPLE_W = SAMPLE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_en,
  input  logic                sclk_en,
  input  logic [DIV_W-1:0]    div,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                bclk,
  output logic                fsync,
  output logic                sdo,
  output logic                underrun
);
  logic                rise;
  logic                slot_start;
  logic [SAMPLE_W-1:0] load_data;

  assign s_ready   = slot_start;
  assign load_data = s_valid ? s_data : '0;

  pcm_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .div(div),
    .bclk(bclk), .rise(rise)
  );

  pcm_slot_ctrl #(.SAMPLE_W(SAMPLE_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sclk_en(sclk_en),
    .rise(rise), .s_valid(s_valid), .slot_start(slot_start),
    .fsync(fsync), .underrun(underrun)
  );

  pcm_shift_reg #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .rise(rise),
    .load(slot_start), .load_data(load_data), .sdo(sdo)
  );

  // R3: no pop opportunity while either gate is closed
  a_r3_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (port_en && sclk_en));
endmodule

// File: tb/tb_pcm_tx_shifter.sv
module tb_pcm_tx_shifter;
  localparam int CLK_P = 10;
  localparam int NV    = 6;
  // {valid, div[7:0], data[15:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'd0, 16'hA5C3},
    {1'b1, 8'd1, 16'h8001},
    {1'b1, 8'd3, 16'hFFFF},
    {1'b0, 8'd2, 16'h1234},
    {1'b1, 8'd0, 16'h0001},
    {1'b1, 8'd2, 16'h7FFE}
  };

  logic clk = 0, rst_n = 0, port_en = 0, sclk_en = 0, s_valid = 0;
  logic [7:0]  div = 0;
  logic [15:0] s_data = 0;
  logic s_ready, bclk, fsync, sdo, underrun;
  int tests = 0, fails = 0, rdy_cnt = 0, rise_cnt = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (s_ready) rdy_cnt++;
  always @(posedge bclk) rise_cnt++;

  pcm_tx_shifter dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sclk_en(sclk_en),
    .div(div), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .bclk(bclk), .fsync(fsync), .sdo(sdo), .underrun(underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic grab_bits(input int n, inout logic [15:0] w);
    for (int b = 0; b < n; b++) begin
      @(posedge bclk); #1;
      w = {w[14:0], sdo};
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] w;
    realtime t1;
    // R10 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset outputs", {bclk, fsync, sdo, underrun, s_ready}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R10 first cycle after reset", {bclk, fsync, sdo, underrun, s_ready}, 0);

    port_en = 1; sclk_en = 1;
    for (int i = 0; i < NV; i++) begin
      s_valid = VEC[i][24];
      div     = VEC[i][23:16];
      s_data  = VEC[i][15:0];
      @(posedge fsync); #1;
      chk("R2 fsync at slot start", fsync, 1);
      chk("R5 underrun flag", underrun, !VEC[i][24]);
      w = 0;
      @(posedge bclk); t1 = $realtime; #1;
      chk("R2 fsync one bit wide", fsync, 0);
      w = {w[14:0], sdo};
      @(posedge bclk);
      chk("R1 bclk period", int'(($realtime - t1) / CLK_P), 2 * (int'(VEC[i][23:16]) + 1));
      #1; w = {w[14:0], sdo};
      grab_bits(14, w);
      chk(VEC[i][24] ? "R4 serial word" : "R5 zeros on underrun",
          w, VEC[i][24] ? VEC[i][15:0] : 16'h0);
    end

    // R6 port disable mid-sample
    s_valid = 1; div = 1; s_data = 16'hC35A;
    @(posedge fsync); #1;
    grab_bits(5, w);
    port_en = 0;
    @(posedge clk); #1;
    chk("R6 sdo low", sdo, 0);
    chk("R6 fsync low", fsync, 0);
    begin
      int r0, k0;
      r0 = rdy_cnt; k0 = rise_cnt;
      repeat (300) @(posedge clk);
      #1;
      chk("R6 no pops while disabled", rdy_cnt - r0, 0);
      chk("R6 sdo still low", sdo, 0);
      chk("R6 bclk still running", (rise_cnt - k0) > 0, 1);
    end
    // R7 restart in a fresh slot
    s_data = 16'h6B29;
    port_en = 1;
    @(posedge bclk); #1;
    chk("R7 first rise starts slot", fsync, 1);
    w = 0;
    grab_bits(16, w);
    chk("R7 fresh word", w, 16'h6B29);

    // R8/R9 clock stop mid-word
    s_data = 16'h9E17;
    @(posedge fsync); #1;
    w = 0;
    grab_bits(6, w);
    sclk_en = 0;
    @(posedge clk); #1;
    chk("R8 bclk parked", bclk, 0);
    chk("R8 fsync parked", fsync, 0);
    begin
      int r0, k0;
      r0 = rdy_cnt; k0 = rise_cnt;
      repeat (200) @(posedge clk);
      #1;
      chk("R8 no pops while stopped", rdy_cnt - r0, 0);
      chk("R8 no bclk edges", rise_cnt - k0, 0);
    end
    sclk_en = 1;
    grab_bits(10, w);
    chk("R9 word intact after resume", w, 16'h9E17);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule